// File: doc/BRIEF.md
# Output Fault Retry Controller

This block supervises the two outputs of a power front-end: a main output that a host switches with an active-low enable pin, and a standby output that runs whenever input power is present. Comparator flags for overvoltage, undervoltage, overcurrent, short circuit and overtemperature arrive per output. The block qualifies them and drives one enable signal per output. Each output is handled on its own: a fault turns off only the output that reported it.

Most faults put the output into a long off interval, after which it restarts by itself. Each restart is counted, and once the restart budget is used up the next fault latches the output off. An overvoltage latches at once. A standby overcurrent instead uses a short hiccup cycle that repeats with no limit and is not counted. Latches and counts clear when input power goes away, or when the enable pin is released and then asserted again. All timing runs on a millisecond tick that the block divides from its clock. The interface carries no data stream: every pin is a plain level for control or status, so no handshake or back-pressure applies.

Top module: `fault_retry_ctrl`

## Requirements
- R1: The main enable is high only while input power is present, the enable pin is low and the main output is neither off for a fault nor latched. The standby enable is high while input power is present and standby is neither off for a fault nor latched, whatever the enable pin does.
- R2: An overtemperature or undervoltage flag, or a qualified overcurrent or short circuit, turns its output off for OFF_MS ticks. The output then restarts and its restart count goes up by one.
- R3: When a retry-class fault arrives with the restart count already at MAX_RETRY, the output latches off, its latched status goes high and the count stays at MAX_RETRY.
- R4: An overvoltage flag on either output latches that output off within a few clock cycles, with no restart and no change to its restart count.
- R5: A main overcurrent shuts the output down only after the flag has stayed high for OC_BLANK_MS ticks. If the flag drops before then, the blanking time starts again from zero.
- R6: A main short-circuit flag held for SC_QUAL_MS ticks (5 ms by default, inside the 10 ms limit) counts as a retry-class fault.
- R7: A standby overcurrent turns standby off within a few clock cycles. Standby then retries every HICCUP_MS ticks, with no limit and no change to the restart count or latched status.
- R8: A fault on one output leaves the enable, count and latched status of the other output unchanged.
- R9: Loss of input power turns both outputs off and clears both latches and both restart counts.
- R10: A high-then-low transition of the synchronised enable pin clears both latches and both counts. Holding the pin high only turns the main output off and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Input power present (asynchronous) |
| en_n_i | input | 1 | Active-low main enable pin (asynchronous) |
| main_ov_i | input | 1 | Main overvoltage comparator |
| main_uv_i | input | 1 | Main undervoltage comparator (below 93 %) |
| main_oc_i | input | 1 | Main overcurrent comparator |
| main_sc_i | input | 1 | Main short-circuit comparator (below 3 V) |
| main_ot_i | input | 1 | Main overtemperature comparator |
| stby_ov_i | input | 1 | Standby overvoltage comparator |
| stby_uv_i | input | 1 | Standby undervoltage comparator |
| stby_oc_i | input | 1 | Standby overcurrent comparator |
| stby_ot_i | input | 1 | Standby overtemperature comparator |
| main_en_o | output | 1 | Main output enable |
| stby_en_o | output | 1 | Standby output enable |
| main_latched_o | output | 1 | Main output latched off |
| stby_latched_o | output | 1 | Standby output latched off |
| main_retries_o | output | CW | Main restart count |
| stby_retries_o | output | CW | Standby restart count |

## Verification
On every cycle the assertions check four things: an overvoltage on a running output leads to the latched state, a latch stays set until a clear arrives, a clear zeroes the count and the latch, and a hiccup never changes the restart count. Inside the persistence filters they also check that qualification needs an unbroken flag history. Only the bench scenarios can show the timing windows: the length of the off interval, the overcurrent blanking time and its restart, the short-circuit qualification time, and the hiccup period. The same goes for the restart budget running out, isolation between the outputs, and the difference between holding the enable pin high and toggling it.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_REST = 2'd1,
    ST_HIC  = 2'd2,
    ST_LOCK = 2'd3
  } frc_state_e;

  function automatic int frc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/frc_tick_gen.sv
module frc_tick_gen #(
  parameter int TICK_DIV = 100000,
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          div_q <= '0;
    else if (div_q == DW'(TICK_DIV - 1)) div_q <= '0;
    else                                 div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == DW'(TICK_DIV - 1));
endmodule

// File: rtl/frc_sync.sv
module frc_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/frc_persist.sv
module frc_persist #(
  parameter int HOLD_MS = 22,
  localparam int PW = $clog2(HOLD_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flag_i,
  output logic qual_o
);
  logic [PW-1:0] span_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   span_q <= '0;
    else if (!flag_i)                             span_q <= '0;
    else if (tick && span_q != PW'(HOLD_MS))      span_q <= span_q + 1'b1;
  end

  assign qual_o = flag_i && (span_q == PW'(HOLD_MS));

  a_r5_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_o) |-> $past(flag_i));
  a_r5_drop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_i |=> !qual_o);
endmodule

// File: rtl/frc_out_fsm.sv
module frc_out_fsm
  import frc_pkg::*;
#(
  parameter int OFF_MS    = 10000,
  parameter int HICCUP_MS = 1000,
  parameter int MAX_RETRY = 5,
  parameter bit HICCUP_EN = 1'b0,
  localparam int CW = $clog2(MAX_RETRY + 1),
  localparam int TW = $clog2(frc_max(OFF_MS, HICCUP_MS) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic          live,
  input  logic          f_retry,
  input  logic          f_latch,
  input  logic          f_hiccup,
  output logic          en_o,
  output logic          latched_o,
  output logic [CW-1:0] retries_o
);
  frc_state_e    st_q;
  logic [TW-1:0] tmr_q;
  logic [CW-1:0] cnt_q;
  logic          hic_req;

  generate
    if (HICCUP_EN) begin : g_hic
      assign hic_req = f_hiccup;
    end else begin : g_nohic
      assign hic_req = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      tmr_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      st_q  <= ST_RUN;
      tmr_q <= '0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (live) begin
            if (f_latch) begin
              st_q <= ST_LOCK;
            end else if (f_retry) begin
              if (cnt_q == CW'(MAX_RETRY)) st_q <= ST_LOCK;
              else begin
                st_q  <= ST_REST;
                tmr_q <= '0;
              end
            end else if (hic_req) begin
              st_q  <= ST_HIC;
              tmr_q <= '0;
            end
          end
        end
        ST_REST: begin
          if (tick) begin
            if (tmr_q == TW'(OFF_MS - 1)) begin
              st_q  <= ST_RUN;
              cnt_q <= cnt_q + 1'b1;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
        end
        ST_HIC: begin
          if (tick) begin
            if (tmr_q == TW'(HICCUP_MS - 1)) st_q <= ST_RUN;
            else                             tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st_q <= ST_LOCK;
      endcase
    end
  end

  assign en_o      = live && (st_q == ST_RUN);
  assign latched_o = (st_q == ST_LOCK);
  assign retries_o = cnt_q;

  a_r4_ov_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && f_latch && !clr) |=> latched_o);
  a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && !clr) |=> latched_o);
  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (retries_o == '0 && !latched_o));
  a_r7_hiccup_uncounted: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HIC && !clr) |=> $stable(retries_o));
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl #(
  parameter int TICK_DIV    = 100000,
  parameter int OFF_MS      = 10000,
  parameter int HICCUP_MS   = 1000,
  parameter int OC_BLANK_MS = 22,
  parameter int SC_QUAL_MS  = 5,
  parameter int MAX_RETRY   = 5,
  localparam int CW = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok_i,
  input  logic          en_n_i,
  input  logic          main_ov_i,
  input  logic          main_uv_i,
  input  logic          main_oc_i,
  input  logic          main_sc_i,
  input  logic          main_ot_i,
  input  logic          stby_ov_i,
  input  logic          stby_uv_i,
  input  logic          stby_oc_i,
  input  logic          stby_ot_i,
  output logic          main_en_o,
  output logic          stby_en_o,
  output logic          main_latched_o,
  output logic          stby_latched_o,
  output logic [CW-1:0] main_retries_o,
  output logic [CW-1:0] stby_retries_o
);
  localparam int NIN   = 11;
  localparam int I_PWR = 10;
  localparam int I_EN  = 9;
  localparam logic [NIN-1:0] SYNC_RST = NIN'(1) << I_EN;

  logic [NIN-1:0] raw, syn;
  logic tick, en_n_d, en_fall, clr;
  logic main_live, oc_gate, sc_gate, oc_q, sc_q, main_retry;

  assign raw = {pwr_ok_i, en_n_i, main_ov_i, main_uv_i, main_oc_i, main_sc_i,
                main_ot_i, stby_ov_i, stby_uv_i, stby_oc_i, stby_ot_i};

  frc_sync #(.W(NIN), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

  frc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_n_d <= 1'b1;
    else        en_n_d <= syn[I_EN];
  end

  assign en_fall   = en_n_d && !syn[I_EN];
  assign clr       = !syn[I_PWR] || en_fall;
  assign main_live = syn[I_PWR] && !syn[I_EN];

  assign oc_gate = syn[6] && main_en_o;
  assign sc_gate = syn[5] && main_en_o;

  frc_persist #(.HOLD_MS(OC_BLANK_MS)) u_oc_blank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flag_i(oc_gate), .qual_o(oc_q));

  frc_persist #(.HOLD_MS(SC_QUAL_MS)) u_sc_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flag_i(sc_gate), .qual_o(sc_q));

  assign main_retry = syn[4] || syn[7] || oc_q || sc_q;

  frc_out_fsm #(.OFF_MS(OFF_MS), .HICCUP_MS(HICCUP_MS), .MAX_RETRY(MAX_RETRY),
                .HICCUP_EN(1'b0)) u_main (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .live(main_live),
    .f_retry(main_retry), .f_latch(syn[8]), .f_hiccup(1'b0),
    .en_o(main_en_o), .latched_o(main_latched_o), .retries_o(main_retries_o));

  frc_out_fsm #(.OFF_MS(OFF_MS), .HICCUP_MS(HICCUP_MS), .MAX_RETRY(MAX_RETRY),
                .HICCUP_EN(1'b1)) u_stby (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .live(syn[I_PWR]),
    .f_retry(syn[0] || syn[2]), .f_latch(syn[3]), .f_hiccup(syn[1]),
    .en_o(stby_en_o), .latched_o(stby_latched_o), .retries_o(stby_retries_o));
endmodule

// File: tb/tb_fault_retry_ctrl.sv
module tb_fault_retry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TD   = 20;
  localparam int OFFM = 10;
  localparam int HICM = 4;
  localparam int OCB  = 6;
  localparam int SCQ  = 3;
  localparam int MAXR = 5;
  localparam int CW   = $clog2(MAXR + 1);

  logic clk = 0, rst_n = 0, pwr_ok = 0, en_n = 0;
  logic m_ov = 0, m_uv = 0, m_oc = 0, m_sc = 0, m_ot = 0;
  logic s_ov = 0, s_uv = 0, s_oc = 0, s_ot = 0;
  logic m_en, s_en, m_lat, s_lat;
  logic [CW-1:0] m_cnt, s_cnt;
  int errors = 0, checks = 0;
  bit done = 0;
  int mdl_cnt[2];
  bit mdl_lat[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_retry_ctrl #(.TICK_DIV(TD), .OFF_MS(OFFM), .HICCUP_MS(HICM),
    .OC_BLANK_MS(OCB), .SC_QUAL_MS(SCQ), .MAX_RETRY(MAXR)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .en_n_i(en_n),
    .main_ov_i(m_ov), .main_uv_i(m_uv), .main_oc_i(m_oc), .main_sc_i(m_sc),
    .main_ot_i(m_ot), .stby_ov_i(s_ov), .stby_uv_i(s_uv), .stby_oc_i(s_oc),
    .stby_ot_i(s_ot), .main_en_o(m_en), .stby_en_o(s_en),
    .main_latched_o(m_lat), .stby_latched_o(s_lat),
    .main_retries_o(m_cnt), .stby_retries_o(s_cnt));

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int en_of(input int w);
    return (w == 0) ? int'(m_en) : int'(s_en);
  endfunction
  function automatic int cnt_of(input int w);
    return (w == 0) ? int'(m_cnt) : int'(s_cnt);
  endfunction
  function automatic int lat_of(input int w);
    return (w == 0) ? int'(m_lat) : int'(s_lat);
  endfunction
  function automatic bit next_locks(input int cnt);
    return cnt == MAXR;
  endfunction

  task automatic set_flag(input int w, input int kind, input logic v);
    if (w == 0) begin
      if (kind == 0) m_ot = v; else m_uv = v;
    end else begin
      if (kind == 0) s_ot = v; else s_uv = v;
    end
  endtask

  // R2 / R3 / R8: a retry-class fault on output w
  task automatic retry_fault(input int w, input int kind);
    int other = 1 - w;
    int other_cnt = cnt_of(other);
    set_flag(w, kind, 1'b1);
    cyc(3);
    set_flag(w, kind, 1'b0);
    if (next_locks(mdl_cnt[w])) begin
      cyc(6);
      chk("R3 latched", lat_of(w), 1);
      chk("R3 enable off", en_of(w), 0);
      chk("R3 count held", cnt_of(w), MAXR);
      mdl_lat[w] = 1;
    end else begin
      cyc((OFFM - 1) * TD - 4);
      chk("R2 off during rest", en_of(w), 0);
      chk("R8 other stays on", en_of(other), 1);
      chk("R8 other count", cnt_of(other), other_cnt);
      cyc(2 * TD + 10);
      mdl_cnt[w]++;
      chk("R2 restarted", en_of(w), 1);
      chk("R2 count", cnt_of(w), mdl_cnt[w]);
    end
  endtask

  // R10: toggle of the enable pin clears both outputs
  task automatic toggle_clear();
    en_n = 1;
    cyc(6);
    chk("R10 main off while high", m_en, 0);
    chk("R10 latch kept while high", m_lat, int'(mdl_lat[0]));
    chk("R1 standby ignores pin", s_en, mdl_lat[1] ? 0 : 1);
    en_n = 0;
    cyc(6);
    mdl_cnt = '{0, 0};
    mdl_lat = '{0, 0};
    chk("R10 main on", m_en, 1);
    chk("R10 main cleared", int'(m_cnt) + int'(m_lat), 0);
    chk("R10 stby cleared", int'(s_cnt) + int'(s_lat), 0);
  endtask

  initial begin
    void'($urandom(32'd1427));
    mdl_cnt = '{0, 0};
    mdl_lat = '{0, 0};
    cyc(3);
    chk("R1 reset main", m_en, 0);
    chk("R1 reset stby", s_en, 0);
    rst_n = 1;
    pwr_ok = 1;
    cyc(10);
    chk("R1 main on", m_en, 1);
    chk("R1 stby on", s_en, 1);
    chk("R1 counts zero", int'(m_cnt) + int'(s_cnt), 0);
    toggle_clear();

    // R5: short overcurrent is blanked
    m_oc = 1;
    cyc((OCB - 1) * TD - 4);
    m_oc = 0;
    cyc(5);
    chk("R5 blanked burst", m_en, 1);
    chk("R5 no count", m_cnt, 0);
    m_oc = 1;
    cyc((OCB - 1) * TD - 4);
    chk("R5 blank restarted", m_en, 1);
    cyc(2 * TD + 10);
    chk("R5 persistent trips", m_en, 0);
    chk("R8 stby unaffected", s_en, 1);
    m_oc = 0;
    cyc((OFFM + 1) * TD);
    mdl_cnt[0] = 1;
    chk("R2 oc restart", m_en, 1);
    chk("R2 oc count", m_cnt, 1);

    // R6: short circuit
    m_sc = 1;
    cyc((SCQ + 1) * TD + 5);
    chk("R6 sc trips", m_en, 0);
    m_sc = 0;
    cyc(OFFM * TD);
    mdl_cnt[0] = 2;
    chk("R6 sc restart", m_en, 1);
    chk("R6 sc count", m_cnt, 2);

    // R7: standby hiccup
    s_oc = 1;
    cyc(4);
    chk("R7 immediate off", s_en, 0);
    chk("R8 main unaffected", m_en, 1);
    cyc(7 * HICM * TD);
    chk("R7 no count", s_cnt, 0);
    chk("R7 no latch", s_lat, 0);
    s_oc = 0;
    cyc((HICM + 1) * TD + 5);
    chk("R7 recovers", s_en, 1);

    // R4: main overvoltage
    m_ov = 1;
    cyc(3);
    m_ov = 0;
    cyc(4);
    chk("R4 main latched", m_lat, 1);
    chk("R4 main off", m_en, 0);
    chk("R4 count unchanged", m_cnt, 2);
    chk("R8 stby on", s_en, 1);
    mdl_lat[0] = 1;
    toggle_clear();

    // R3: budget exhaustion
    for (int i = 0; i <= MAXR; i++) retry_fault(0, i % 2);
    pwr_ok = 0;
    cyc(5);
    chk("R9 main off", m_en, 0);
    chk("R9 stby off", s_en, 0);
    pwr_ok = 1;
    cyc(6);
    mdl_cnt = '{0, 0};
    mdl_lat = '{0, 0};
    chk("R9 main cleared", int'(m_lat) + int'(m_cnt), 0);
    chk("R9 main back", m_en, 1);

    // R4: standby overvoltage
    s_ov = 1;
    cyc(3);
    s_ov = 0;
    cyc(4);
    chk("R4 stby latched", s_lat, 1);
    chk("R8 main on", m_en, 1);
    mdl_lat[1] = 1;
    toggle_clear();

    // random mix
    for (int k = 0; k < 14; k++) begin
      int w = $urandom % 2;
      int kind = $urandom % 3;
      if (kind == 2 || mdl_lat[w]) toggle_clear();
      else retry_fault(w, kind);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule